// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

The block is one bank of 32 general-purpose lines, grouped as four 8-bit ports (A, B, C, D), placed behind a plain 32-bit register bus with per-byte write strobes. Software sets line directions and output levels, reads the pin levels back, and arms an edge interrupt on any line. Each pin input passes through a two-flop synchroniser before an edge detector. Detected edges of the armed kind set sticky status bits, and software clears them by writing ones. A single interrupt output combines every pending, enabled line. A second bank is a second instance of the same block.

In the one-bit-per-line registers the four port bytes sit in reversed lane order, so port A occupies the most significant byte of a 32-bit access. Trigger configuration uses two bits per line. Each port therefore fills a halfword, and the configuration spans two words, each holding a pair of ports. One 2-bit field serves as both the enable and the edge select for its line.

Top module: `gpio_bank`

## Requirements
- R1: After reset, all line outputs are low, all output enables are off, every trigger field and status bit is zero, and `irq_o` is low.
- R2: Word index 0 is the level register, 1 the direction register and 2 the status register. In these three, port A sits at bus bits 31:24, B at 23:16, C at 15:8 and D at 7:0, with pin k of a port at bit k of its byte. Word indices 5, 6 and 7 read as zero, and writes to them change nothing.
- R3: `bus_be_i[i]` enables write data bits 8i+7:8i. Bytes whose strobe is low keep their value, and a write with no strobe set changes no register.
- R4: `pin_oe_o` follows the direction register (1 = drive) and `pin_out_o` follows the level register, both in line order. A read of word 0 returns the written level for output lines and the synchronised pin for input lines. A pin change driven before a rising edge is readable no later than after the third rising edge.
- R5: Word 3 holds the trigger fields of port A in bits 31:16 and port B in bits 15:0. Word 4 holds port C in bits 31:16 and port D in bits 15:0. Pin k of a port uses bits 2k+1:2k of its halfword.
- R6: The field encoding is 00 = off, 01 = falling edge, 10 = rising edge and 11 = either edge. A status bit sets only on an edge of the kind its field enables.
- R7: Writing a 1 to a status bit clears it, and writing a 0 leaves it as it is. Writing all ones with all strobes set clears every pending bit.
- R8: If an enabled edge on a line and a clearing write to the same status bit fall in the same cycle, the bit ends up set.
- R9: `irq_o` is high exactly when some status bit is set whose trigger field is non-zero. Setting a field to 00 hides that line's pending bit from `irq_o` but keeps the bit readable.
- R10: Pin levels present when reset is released produce no status bit, even if a trigger is armed in the first cycles after release.
- R11: An enabled edge driven before rising edge n sets its status bit and raises `irq_o` at rising edge n+2, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel_i | input | 1 | Bus access in this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_word_i | input | 3 | Word index of the access (byte offset / 4) |
| bus_be_i | input | 4 | Byte write strobes, bit i for data bits 8i+7:8i |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed word, same cycle; zero when not selected |
| pin_in_i | input | 32 | Asynchronous pin levels, line n at bit n |
| pin_out_o | output | 32 | Output levels, line n at bit n |
| pin_oe_o | output | 32 | Output enables, line n at bit n |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A wrong lane or halfword mapping shows at the ports immediately: the byte written through the bus appears on the wrong group of `pin_out_o`, or an edge on one line raises a status bit for another line in the status word read back two edges later. A corrupted synchroniser or arming stage shows as a status bit present after reset with no edge, or as `irq_o` rising one cycle early or late relative to the pin change. Errors in the set and clear logic show on the next status read after the write that collided with an edge. A field that enables the wrong edge kind shows as a missing or extra bit after a single pin transition.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
  localparam int unsigned PORT_W   = 8;
  localparam int unsigned NPORT    = 4;
  localparam int unsigned NLINE    = PORT_W * NPORT;
  localparam int unsigned CFG_W    = 2;
  localparam int unsigned CFG_BITS = CFG_W * NLINE;
  localparam int unsigned CFG_BYTES = CFG_BITS / PORT_W;

  typedef enum logic [2:0] {
    W_LEVEL = 3'd0,
    W_DIR   = 3'd1,
    W_STAT  = 3'd2,
    W_TRIG0 = 3'd3,
    W_TRIG1 = 3'd4
  } word_e;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'b00,
    TRIG_FALL = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_BOTH = 2'b11
  } trig_e;

  // Swap between line order (port A low) and bus lane order (port A high).
  function automatic logic [NLINE-1:0] lane_swap(input logic [NLINE-1:0] v);
    logic [NLINE-1:0] r;
    for (int p = 0; p < NPORT; p++) begin
      r[(NPORT-1-p)*PORT_W +: PORT_W] = v[p*PORT_W +: PORT_W];
    end
    return r;
  endfunction
endpackage

// File: rtl/gpb_rst_sync.sv
module gpb_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_no = stage_q[1];
endmodule

// File: rtl/gpb_edge_sync.sv
module gpb_edge_sync #(
  parameter int unsigned W = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [W-1:0]   pin_i,
  input  logic [2*W-1:0] cfg_i,
  output logic [W-1:0]   lvl_o,
  output logic [W-1:0]   hit_o
);
  localparam int unsigned ARM_D = 3;

  logic [W-1:0]     meta_q, sync_q, prev_q;
  logic [ARM_D-1:0] arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
      arm_q  <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
      arm_q  <= {arm_q[ARM_D-2:0], 1'b1};
    end
  end

  assign lvl_o = sync_q;

  for (genvar i = 0; i < W; i++) begin : g_line
    logic rise, fall;
    assign rise     = sync_q[i] & ~prev_q[i];
    assign fall     = ~sync_q[i] & prev_q[i];
    assign hit_o[i] = arm_q[ARM_D-1] &
                      ((cfg_i[2*i+1] & rise) | (cfg_i[2*i] & fall));
  end

  // R11: a detected edge always follows a synchronised change of level
  a_r11_hit_follows_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o != '0) |-> ($past(meta_q) == sync_q) && ((hit_o & ~(sync_q ^ prev_q)) == '0));
endmodule

// File: rtl/gpb_regs.sv
module gpb_regs #(
  parameter int unsigned PORT_W = 8,
  parameter int unsigned NPORT  = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NPORT-1:0]          lvl_we_i,
  input  logic [NPORT-1:0]          dir_we_i,
  input  logic [2*NPORT-1:0]        cfg_we_i,
  input  logic [PORT_W*NPORT-1:0]   wline_i,
  input  logic [2*PORT_W*NPORT-1:0] wcfg_i,
  output logic [PORT_W*NPORT-1:0]   lvl_q,
  output logic [PORT_W*NPORT-1:0]   dir_q,
  output logic [2*PORT_W*NPORT-1:0] cfg_q
);
  localparam int unsigned LW = PORT_W * NPORT;
  localparam int unsigned CW = 2 * LW;

  logic [LW-1:0] lvl_d, dir_d;
  logic [CW-1:0] cfg_d;
  logic          upd;

  always_comb begin
    lvl_d = lvl_q;
    dir_d = dir_q;
    cfg_d = cfg_q;
    for (int p = 0; p < NPORT; p++) begin
      if (lvl_we_i[p]) lvl_d[p*PORT_W +: PORT_W] = wline_i[p*PORT_W +: PORT_W];
      if (dir_we_i[p]) dir_d[p*PORT_W +: PORT_W] = wline_i[p*PORT_W +: PORT_W];
    end
    for (int k = 0; k < 2*NPORT; k++) begin
      if (cfg_we_i[k]) cfg_d[k*PORT_W +: PORT_W] = wcfg_i[k*PORT_W +: PORT_W];
    end
  end

  assign upd = (|lvl_we_i) | (|dir_we_i) | (|cfg_we_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      dir_q <= '0;
      cfg_q <= '0;
    end else if (upd) begin
      lvl_q <= lvl_d;
      dir_q <= dir_d;
      cfg_q <= cfg_d;
    end
  end
endmodule

// File: rtl/gpb_irq.sv
module gpb_irq #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] hit_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] stat_q,
  output logic         irq_o
);
  logic [W-1:0] stat_d;
  logic         upd;

  always_comb begin
    stat_d = (stat_q & ~clr_i) | hit_i;
    upd    = (|hit_i) | (|clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  stat_q <= '0;
    else if (upd) stat_q <= stat_d;
  end

  assign irq_o = |(stat_q & en_i);

  // R8: an edge sets its bit even when a clear hits it in the same cycle
  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i != '0) |=> ((stat_q & $past(hit_i)) == $past(hit_i)));

  // R7: a cleared bit with no edge is zero afterwards
  a_r7_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~hit_i) != '0) |=> ((stat_q & $past(clr_i & ~hit_i)) == '0));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int unsigned WORD_AW = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      bus_sel_i,
  input  logic                      bus_we_i,
  input  logic [WORD_AW-1:0]        bus_word_i,
  input  logic [gpb_pkg::NPORT-1:0] bus_be_i,
  input  logic [gpb_pkg::NLINE-1:0] bus_wdata_i,
  output logic [gpb_pkg::NLINE-1:0] bus_rdata_o,
  input  logic [gpb_pkg::NLINE-1:0] pin_in_i,
  output logic [gpb_pkg::NLINE-1:0] pin_out_o,
  output logic [gpb_pkg::NLINE-1:0] pin_oe_o,
  output logic                      irq_o
);
  import gpb_pkg::*;

  localparam int unsigned HALF_W = CFG_W * PORT_W;
  localparam int unsigned PPW    = NLINE / HALF_W;  // ports per trigger word

  logic              rst_n;
  logic              wr;
  word_e             widx;
  logic [NLINE-1:0]  wline, lvl, dir, stat, sync_lvl, hit, clr, en_lines;
  logic [NPORT-1:0]  be_line, lvl_we, dir_we;
  logic [CFG_BYTES-1:0] cfg_we;
  logic [CFG_BITS-1:0]  wcfg, cfg;
  logic [NLINE-1:0]  rsel;

  gpb_rst_sync u_rst (.clk_i(clk_i), .rst_ni(rst_ni), .rst_no(rst_n));

  assign wr    = bus_sel_i & bus_we_i;
  assign widx  = word_e'(bus_word_i);
  assign wline = lane_swap(bus_wdata_i);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign be_line[p] = bus_be_i[NPORT-1-p];
    assign lvl_we[p]  = wr & (widx == W_LEVEL) & be_line[p];
    assign dir_we[p]  = wr & (widx == W_DIR)   & be_line[p];
    assign clr[p*PORT_W +: PORT_W] =
      (wr && widx == W_STAT && be_line[p]) ? wline[p*PORT_W +: PORT_W] : '0;
  end

  // Trigger bytes in line order: byte k belongs to port k/2, half k%2.
  // Even ports take the upper halfword of their word, odd ports the lower.
  for (genvar k = 0; k < CFG_BYTES; k++) begin : g_cfg_byte
    localparam int unsigned PORT = k / 2;
    localparam int unsigned WOFS = PORT / PPW;
    localparam int unsigned LANE = ((PORT % PPW) == 0 ? 2 : 0) + (k % 2);
    assign cfg_we[k] = wr & (bus_word_i == WORD_AW'(W_TRIG0) + WORD_AW'(WOFS))
                          & bus_be_i[LANE];
    assign wcfg[k*PORT_W +: PORT_W] = bus_wdata_i[LANE*PORT_W +: PORT_W];
  end

  for (genvar i = 0; i < NLINE; i++) begin : g_en
    assign en_lines[i] = |cfg[CFG_W*i +: CFG_W];
  end

  gpb_regs #(.PORT_W(PORT_W), .NPORT(NPORT)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_n),
    .lvl_we_i(lvl_we), .dir_we_i(dir_we), .cfg_we_i(cfg_we),
    .wline_i(wline), .wcfg_i(wcfg),
    .lvl_q(lvl), .dir_q(dir), .cfg_q(cfg)
  );

  gpb_edge_sync #(.W(NLINE)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_n),
    .pin_i(pin_in_i), .cfg_i(cfg),
    .lvl_o(sync_lvl), .hit_o(hit)
  );

  gpb_irq #(.W(NLINE)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_n),
    .hit_i(hit), .clr_i(clr), .en_i(en_lines),
    .stat_q(stat), .irq_o(irq_o)
  );

  always_comb begin
    unique case (widx)
      W_LEVEL: rsel = lane_swap((lvl & dir) | (sync_lvl & ~dir));
      W_DIR:   rsel = lane_swap(dir);
      W_STAT:  rsel = lane_swap(stat);
      W_TRIG0: rsel = {cfg[0*HALF_W +: HALF_W], cfg[1*HALF_W +: HALF_W]};
      W_TRIG1: rsel = {cfg[2*HALF_W +: HALF_W], cfg[3*HALF_W +: HALF_W]};
      default: rsel = '0;
    endcase
  end

  assign bus_rdata_o = bus_sel_i ? rsel : '0;
  assign pin_out_o   = lvl;
  assign pin_oe_o    = dir;

  // R6: a status bit only newly sets on a line whose trigger was armed
  a_r6_set_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_n)
    1'b1 |=> ((stat & ~$past(stat) & ~$past(en_lines)) == '0));

  // R3: a write with no strobe leaves every register unchanged
  a_r3_empty_strobe: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr && bus_be_i == '0) |=> ($stable(lvl) && $stable(dir) && $stable(cfg)));

  // R2: writes to unused word indices change nothing
  a_r2_unused_words: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr && bus_word_i > WORD_AW'(W_TRIG1)) |=> ($stable(lvl) && $stable(dir) && $stable(cfg)));

  // R9: with every trigger field off, no interrupt is requested
  a_r9_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_n)
    (en_lines == '0) |-> !irq_o);
endmodule

// File: tb/gpio_bank_bench.sv
module gpio_bank_bench;
  logic        clk, rst_n;
  logic        sel, we;
  logic [2:0]  word;
  logic [3:0]  be;
  logic [31:0] wdata, rdata, pins, pout, poe;
  logic        irq;
  int          total, bad;
  bit          done;

  gpio_bank u_gpio_bank (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_word_i(word), .bus_be_i(be), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pin_in_i(pins), .pin_out_o(pout), .pin_oe_o(poe), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr_word(input logic [2:0] w, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; word = w; wdata = d; be = b;
    @(negedge clk);
    sel = 1'b0; we = 1'b0; be = 4'h0;
  endtask

  task automatic rd_word(input logic [2:0] w, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; word = w;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 pin_out", pout, 32'h0);
    chk("R1 pin_oe", poe, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    rd_word(3'd1, d); chk("R1 dir", d, 32'h0);
    rd_word(3'd3, d); chk("R1 trig0", d, 32'h0);
    rd_word(3'd2, d); chk("R1 stat", d, 32'h0);
  endtask

  task automatic t_lanes;
    logic [31:0] d;
    wr_word(3'd1, 32'hFFFF_FFFF, 4'hF);
    wr_word(3'd0, 32'h1122_3344, 4'hF);
    chk("R4 pin_oe", poe, 32'hFFFF_FFFF);
    chk("R2 pin_out lane order", pout, 32'h4433_2211);
    rd_word(3'd0, d); chk("R2 level read", d, 32'h1122_3344);
    wr_word(3'd5, 32'hFFFF_FFFF, 4'hF);
    wr_word(3'd6, 32'h0000_0000, 4'hF);
    rd_word(3'd5, d); chk("R2 word5 zero", d, 32'h0);
    rd_word(3'd6, d); chk("R2 word6 zero", d, 32'h0);
    rd_word(3'd1, d); chk("R2 dir kept", d, 32'hFFFF_FFFF);
    rd_word(3'd0, d); chk("R2 level kept", d, 32'h1122_3344);
  endtask

  task automatic t_strobe;
    logic [31:0] d;
    wr_word(3'd0, 32'hAABB_CCDD, 4'b0010);
    rd_word(3'd0, d); chk("R3 one lane", d, 32'h1122_CC44);
    chk("R3 pin_out", pout, 32'h44CC_2211);
    wr_word(3'd0, 32'h0000_0000, 4'b0000);
    rd_word(3'd0, d); chk("R3 no strobe", d, 32'h1122_CC44);
  endtask

  task automatic t_input;
    logic [31:0] d;
    wr_word(3'd1, 32'h00FF_FFFF, 4'hF);
    @(negedge clk); pins[7:0] = 8'h5A;
    repeat (3) @(posedge clk);
    rd_word(3'd0, d); chk("R4 input port A", d, 32'h5A22_CC44);
    chk("R4 oe port A off", poe, 32'hFFFF_FF00);
  endtask

  task automatic t_trig_layout;
    logic [31:0] d;
    wr_word(3'd3, 32'h1234_5678, 4'hF);
    wr_word(3'd4, 32'h9ABC_DEF0, 4'hF);
    rd_word(3'd3, d); chk("R5 trig0 back", d, 32'h1234_5678);
    rd_word(3'd4, d); chk("R5 trig1 back", d, 32'h9ABC_DEF0);
    wr_word(3'd4, 32'h0, 4'hF);
    wr_word(3'd3, 32'h0000_0008, 4'hF);   // port B pin 1 (line 9): rising
    wr_word(3'd2, 32'hFFFF_FFFF, 4'hF);
    @(negedge clk); pins[9] = 1'b1;
    idle(4);
    rd_word(3'd2, d); chk("R5 line9 status", d, 32'h0002_0000);
    chk("R5 irq line9", {31'h0, irq}, 32'h1);
    wr_word(3'd3, 32'h0, 4'hF);
    wr_word(3'd2, 32'hFFFF_FFFF, 4'hF);
  endtask

  task automatic t_encoding;
    logic [31:0] d;
    wr_word(3'd4, 32'h0000_00E4, 4'hF);   // lines 24..27: off, fall, rise, both
    @(negedge clk); pins[27:24] = 4'hF;
    idle(4);
    rd_word(3'd2, d); chk("R6 rising edges", d, 32'h0000_000C);
    wr_word(3'd2, 32'hFFFF_FFFF, 4'hF);
    @(negedge clk); pins[27:24] = 4'h0;
    idle(4);
    rd_word(3'd2, d); chk("R6 falling edges", d, 32'h0000_000A);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    wr_word(3'd2, 32'h0000_0002, 4'b0001);
    rd_word(3'd2, d); chk("R7 clear one", d, 32'h0000_0008);
    wr_word(3'd2, 32'h0000_0000, 4'hF);
    rd_word(3'd2, d); chk("R7 zero write", d, 32'h0000_0008);
    wr_word(3'd2, 32'hFFFF_FFFF, 4'h0);
    rd_word(3'd2, d); chk("R7 unstrobed", d, 32'h0000_0008);
    wr_word(3'd2, 32'hFFFF_FFFF, 4'hF);
    rd_word(3'd2, d); chk("R7 clear all", d, 32'h0);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    @(negedge clk); pins[26] = 1'b1;
    idle(4);
    chk("R9 irq set", {31'h0, irq}, 32'h1);
    wr_word(3'd4, 32'h0, 4'hF);
    chk("R9 irq hidden", {31'h0, irq}, 32'h0);
    rd_word(3'd2, d); chk("R9 status kept", d, 32'h0000_0004);
    wr_word(3'd4, 32'h0000_00E4, 4'hF);
    chk("R9 irq back", {31'h0, irq}, 32'h1);
    wr_word(3'd2, 32'hFFFF_FFFF, 4'hF);
    chk("R9 irq cleared", {31'h0, irq}, 32'h0);
    @(negedge clk); pins[26] = 1'b0;
    idle(4);
  endtask

  task automatic t_latency;
    @(negedge clk); pins[26] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R11 not early", {31'h0, irq}, 32'h0);
    @(posedge clk); @(negedge clk);
    chk("R11 on time", {31'h0, irq}, 32'h1);
  endtask

  task automatic t_priority;
    logic [31:0] d;
    wr_word(3'd4, 32'h0000_0030, 4'hF);   // line 26: both edges
    @(negedge clk); pins[26] = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; word = 3'd2; wdata = 32'h0000_0004; be = 4'hF;
    @(negedge clk);
    sel = 1'b0; we = 1'b0; be = 4'h0;
    rd_word(3'd2, d); chk("R8 set beats clear", d, 32'h0000_0004);
    wr_word(3'd2, 32'h0000_0004, 4'hF);
    rd_word(3'd2, d); chk("R8 later clear", d, 32'h0);
  endtask

  task automatic t_arm;
    logic [31:0] d;
    @(negedge clk);
    rst_n = 1'b0;
    pins = 32'h0000_0001;
    sel = 1'b1; we = 1'b1; word = 3'd3; wdata = 32'hFFFF_FFFF; be = 4'hF;
    idle(3);
    rst_n = 1'b1;
    idle(6);
    sel = 1'b0; we = 1'b0; be = 4'h0;
    idle(3);
    rd_word(3'd2, d); chk("R10 no status from reset level", d, 32'h0);
    chk("R10 irq low", {31'h0, irq}, 32'h0);
    chk("R1 oe after reset", poe, 32'h0);
    @(negedge clk); pins[0] = 1'b0;
    idle(4);
    rd_word(3'd2, d); chk("R10 later edge seen", d, 32'h0100_0000);
  endtask

  initial begin
    total = 0; bad = 0; done = 1'b0;
    rst_n = 1'b0; sel = 1'b0; we = 1'b0; word = 3'd0; be = 4'h0;
    wdata = 32'h0; pins = 32'h0;
    idle(4);
    rst_n = 1'b1;
    idle(4);
    t_reset;
    t_lanes;
    t_strobe;
    t_input;
    t_trig_layout;
    t_encoding;
    t_w1c;
    t_irq;
    t_latency;
    t_priority;
    t_arm;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule